// File: doc/BRIEF.md
# Output Compare Pin Action Unit

This block drives an eight-bit timer port from output-compare events. Each channel is marked as output compare or as input by a select bit. When an external compare pulse arrives on a selected channel, the pin of that channel is toggled, cleared or set according to a two-bit action code. The pulse also sets the channel's event flag. Software can fire any channel's action at once through a force register. A forced action does not touch the flag.

Channel 7 has two extra registers, a mask and a data pattern. A channel-7 event loads the pattern into every pin whose mask bit is 1, all in the same step. A set mask bit also locks out that pin's own per-channel action, and it makes the pin an output when the channel is selected as output compare. The stored data-direction value is left as it is. Registers are written through a single-cycle write strobe with an address, and read through a combinational read port. Compare pulses come from comparators outside this block.

Top module: `oc_pin_unit`

## Requirements
- R1: After reset, all registers, pins, output enables and flags are 0, and every read address returns 0.
- R2: On a compare pulse on a selected channel n, pin n changes at the next clock edge according to its action code: 00 leaves it unchanged, 01 inverts it, 10 drives 0, 11 drives 1. The codes for channels 0..3 sit in register 6 at bits [2k+1:2k] for channel k, and those for channels 4..7 sit in register 7 in the same way for channel 4+k.
- R3: A compare pulse on a selected channel n sets flag bit n (read at address 5). Writing 1 to a flag bit clears it. When a set and a clear of the same bit land in the same cycle, the set wins.
- R4: Writing address 1 with bit n set performs channel n's action at the next edge, exactly as a compare pulse would, but leaves flag n unchanged.
- R5: Address 1 always reads 0. A force and a compare pulse on the same channel in the same cycle produce one action only (one inversion, not two).
- R6: A channel whose select bit (address 0) is 0 ignores compare pulses and force writes: its pin keeps its value and its flag is not set.
- R7: On a channel-7 event on a selected channel 7, every pin whose bit in the mask (address 2) is 1 takes the value of the matching bit of the pattern (address 3).
- R8: While a mask bit is 1, a pulse or force on that pin's own channel has no effect on the pin, except through the channel-7 pattern.
- R9: Output enable n is 1 when data-direction bit n (address 4) is 1, or when mask bit n and select bit n are both 1. Writing the mask leaves the data-direction readback unchanged.
- R10: The mask and pattern registers read back the last value written, at any time.
- R11: A forced channel-7 action loads the masked pattern exactly like a real channel-7 pulse, and does not set flag 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data, combinational |
| match_i | input | 8 | Compare pulses, one per channel |
| port_out | output | 8 | Timer port pin values |
| port_oe | output | 8 | Timer port output enables |
| oc_flag | output | 8 | Compare event flags |

## Verification
The bench goes after a force and a pulse on one toggling channel in the same cycle. A design that ORs the two sources wrongly would invert twice and show no change. It clears and sets one flag in the same cycle, where a design with the wrong priority loses the event. It fires channel 7 while a masked pin's own channel also pulses, which shows whether the mask really locks out the per-channel action, and it forces channel 7 to show that a pattern load does not raise flag 7. It also pulses deselected channels to catch a design that acts on inputs, and it checks that mask writes never leak into the data-direction readback or into the enables of input channels.

// File: rtl/oc_pin_unit.sv
module oc_pin_unit #(
  parameter int NCH = 8,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [NCH-1:0] wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [NCH-1:0] rd_data,
  input  logic [NCH-1:0] match_i,
  output logic [NCH-1:0] port_out,
  output logic [NCH-1:0] port_oe,
  output logic [NCH-1:0] oc_flag
);
  localparam int TOP  = NCH - 1;
  localparam logic [AW-1:0] A_SEL = 0, A_FRC = 1, A_MSK = 2, A_PAT = 3,
                            A_DIR = 4, A_FLG = 5, A_MLO = 6, A_MHI = 7;

  logic [NCH-1:0] sel_q, mask_q, pat_q, dir_q, flag_q, mlo_q, mhi_q, pin_q;
  logic [NCH-1:0] pin_d, force_v, ev, clr_v;
  logic [2*NCH-1:0] mode_all;
  logic ev7;

  assign force_v  = (wr_en && wr_addr == A_FRC) ? wr_data : '0;
  assign clr_v    = (wr_en && wr_addr == A_FLG) ? wr_data : '0;
  assign ev       = sel_q & (match_i | force_v);
  assign ev7      = ev[TOP];
  assign mode_all = {mhi_q, mlo_q};

  always_comb begin
    pin_d = pin_q;
    for (int n = 0; n < NCH; n++) begin
      if (mask_q[n]) begin
        if (ev7) pin_d[n] = pat_q[n];
      end else if (ev[n]) begin
        case (mode_all[2*n +: 2])
          2'b01:   pin_d[n] = ~pin_q[n];
          2'b10:   pin_d[n] = 1'b0;
          2'b11:   pin_d[n] = 1'b1;
          default: pin_d[n] = pin_q[n];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; mask_q <= '0; pat_q <= '0; dir_q <= '0;
      flag_q <= '0; mlo_q <= '0; mhi_q <= '0; pin_q <= '0;
    end else begin
      pin_q  <= pin_d;
      flag_q <= (flag_q & ~clr_v) | (sel_q & match_i);
      if (wr_en) begin
        case (wr_addr)
          A_SEL:   sel_q  <= wr_data;
          A_MSK:   mask_q <= wr_data;
          A_PAT:   pat_q  <= wr_data;
          A_DIR:   dir_q  <= wr_data;
          A_MLO:   mlo_q  <= wr_data;
          A_MHI:   mhi_q  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_SEL:   rd_data = sel_q;
      A_MSK:   rd_data = mask_q;
      A_PAT:   rd_data = pat_q;
      A_DIR:   rd_data = dir_q;
      A_FLG:   rd_data = flag_q;
      A_MLO:   rd_data = mlo_q;
      A_MHI:   rd_data = mhi_q;
      default: rd_data = '0;
    endcase
  end

  assign port_out = pin_q;
  assign port_oe  = dir_q | (mask_q & sel_q);
  assign oc_flag  = flag_q;
endmodule

module oc_pin_unit_chk #(
  parameter int NCH = 8,
  parameter int AW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [NCH-1:0] wr_data,
  input logic [AW-1:0]  rd_addr,
  input logic [NCH-1:0] rd_data,
  input logic [NCH-1:0] match_i,
  input logic [NCH-1:0] port_out,
  input logic [NCH-1:0] oc_flag,
  input logic [NCH-1:0] sel_q,
  input logic [NCH-1:0] mask_q,
  input logic [NCH-1:0] pat_q,
  input logic [NCH-1:0] dir_q
);
  logic ev7_c;
  assign ev7_c = sel_q[NCH-1] & (match_i[NCH-1] | (wr_en && wr_addr == AW'(1) && wr_data[NCH-1]));

  assert_flag_only_real_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((oc_flag & ~$past(oc_flag) & ~$past(sel_q & match_i)) == '0));

  assert_pattern_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev7_c |=> (((port_out ^ $past(pat_q)) & $past(mask_q)) == '0));

  assert_masked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev7_c |=> (((port_out ^ $past(port_out)) & $past(mask_q)) == '0));

  assert_input_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((port_out ^ $past(port_out)) & ~$past(sel_q) & ~$past(mask_q)) == '0));

  assert_dir_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(2)) |=> $stable(dir_q));

  assert_force_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AW'(1)) |-> (rd_data == '0));
endmodule

bind oc_pin_unit oc_pin_unit_chk #(.NCH(NCH), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .match_i(match_i), .port_out(port_out),
  .oc_flag(oc_flag), .sel_q(sel_q), .mask_q(mask_q), .pat_q(pat_q), .dir_q(dir_q)
);

// File: tb/test_oc_pin_unit.sv
module test_oc_pin_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, match_i = 0;
  logic [7:0] rd_data, port_out, port_oe, oc_flag;

  int checks = 0, errors = 0;
  string cur = "R1";

  bit m_sel[8], m_msk[8], m_pat[8], m_dir[8], m_flg[8], m_pin[8];
  int m_mode[8];

  oc_pin_unit i_oc_pin_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pack(input bit a[8]);
    for (int i = 0; i < 8; i++) pack[i] = a[i];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_sel[i] <= 0; m_msk[i] <= 0; m_pat[i] <= 0; m_dir[i] <= 0;
        m_flg[i] <= 0; m_pin[i] <= 0; m_mode[i] <= 0;
      end
    end else begin
      bit fired7;
      fired7 = m_sel[7] && (match_i[7] || (wr_en && wr_addr == 1 && wr_data[7]));
      for (int i = 0; i < 8; i++) begin
        bit fired;
        fired = m_sel[i] && (match_i[i] || (wr_en && wr_addr == 1 && wr_data[i]));
        if (m_msk[i]) begin
          if (fired7) m_pin[i] <= m_pat[i];
        end else if (fired) begin
          if (m_mode[i] == 1) m_pin[i] <= !m_pin[i];
          else if (m_mode[i] == 2) m_pin[i] <= 0;
          else if (m_mode[i] == 3) m_pin[i] <= 1;
        end
        if (m_sel[i] && match_i[i]) m_flg[i] <= 1;
        else if (wr_en && wr_addr == 5 && wr_data[i]) m_flg[i] <= 0;
        if (wr_en) begin
          case (wr_addr)
            0: m_sel[i] <= wr_data[i];
            2: m_msk[i] <= wr_data[i];
            3: m_pat[i] <= wr_data[i];
            4: m_dir[i] <= wr_data[i];
            6: if (i < 4) m_mode[i] <= int'(wr_data[2*i +: 2]);
            7: if (i >= 4) m_mode[i] <= int'(wr_data[2*(i-4) +: 2]);
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    logic [7:0] oe_exp;
    oe_exp = pack(m_dir) | (pack(m_msk) & pack(m_sel));
    chk(cur, "model pins", port_out, pack(m_pin));
    chk(cur, "model flags", oc_flag, pack(m_flg));
    chk(cur, "model oe", port_oe, oe_exp);
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d, input logic [7:0] m);
    wr_en = we; wr_addr = a; wr_data = d; match_i = m;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; match_i = 0;
    compare_model();
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, "read", rd_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur = "R1";
    chk("R1", "pins", port_out, 8'h00);
    chk("R1", "oe", port_oe, 8'h00);
    chk("R1", "flags", oc_flag, 8'h00);
    for (int a = 0; a < 8; a++) rd("R1", 3'(a), 8'h00);

    cur = "R2";
    step(1, 0, 8'hFF, 0);
    step(1, 6, 8'hE4, 0);
    step(1, 7, 8'hE4, 0);
    step(0, 0, 0, 8'hFF);
    chk("R2", "mode actions", port_out, 8'hAA);
    cur = "R3";
    chk("R3", "flags set", oc_flag, 8'hFF);
    step(1, 5, 8'h0F, 0);
    chk("R3", "w1c", oc_flag, 8'hF0);
    step(1, 5, 8'h10, 8'h10);
    chk("R3", "set beats clear", oc_flag, 8'hF0);
    step(1, 5, 8'hFF, 0);

    cur = "R4";
    step(1, 1, 8'h02, 0);
    chk("R4", "forced toggle", port_out, 8'hA8);
    chk("R4", "no flag on force", oc_flag, 8'h00);
    cur = "R5";
    rd("R5", 1, 8'h00);
    step(1, 1, 8'h02, 8'h02);
    chk("R5", "single action", port_out, 8'hAA);
    chk("R5", "flag from pulse", oc_flag, 8'h02);
    step(1, 5, 8'hFF, 0);

    cur = "R6";
    step(1, 0, 8'h0F, 0);
    step(0, 0, 0, 8'hF0);
    step(1, 1, 8'hF0, 0);
    chk("R6", "inputs ignored", port_out, 8'hAA);
    chk("R6", "no input flag", oc_flag, 8'h00);

    cur = "R7";
    step(1, 0, 8'hFF, 0);
    step(1, 2, 8'h0F, 0);
    step(1, 3, 8'h05, 0);
    cur = "R10";
    rd("R10", 2, 8'h0F);
    rd("R10", 3, 8'h05);
    cur = "R9";
    chk("R9", "oe from mask", port_oe, 8'h0F);
    rd("R9", 4, 8'h00);
    step(1, 4, 8'h30, 0);
    chk("R9", "oe mix", port_oe, 8'h3F);
    cur = "R7";
    step(0, 0, 0, 8'h80);
    chk("R7", "pattern load", port_out, 8'hA5);
    step(1, 5, 8'hFF, 0);

    cur = "R8";
    step(0, 0, 0, 8'h02);
    chk("R8", "masked pin held", port_out, 8'hA5);
    step(1, 3, 8'h0A, 0);
    cur = "R11";
    step(1, 1, 8'h80, 0);
    chk("R11", "forced pattern", port_out, 8'hAA);
    chk("R11", "no flag7", oc_flag, 8'h02);

    cur = "R2";
    for (int k = 0; k < 400; k++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 7));
      step(($urandom_range(0, 2) == 0), a, 8'($urandom), 8'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule